// File: doc/BRIEF.md
# MMU Translation Exception Classifier

This unit sits next to a translation lookaside buffer and judges the outcome of one address translation per cycle. From the lookup hit flag, the permission bits of the matching entry, the kind of access and the current exception-handling state, it decides whether the access may go ahead. If it may not, the unit raises an exception request, picks the handler address and reports a cause code. The exception request, cause and handler address are combinational outputs in the same cycle as the access.

A translation miss goes to a dedicated fast handler when no exception is being serviced. The same miss goes to the general handler when the handling bit is already set. When an entry matches but its permission bits deny the access, the unit raises an execute, read or write violation, chosen by the access kind.

On each exception, the unit records the cause and an instruction-or-data flag in registers, so a handler can read them later. It also keeps the exception-handling bit. A fast miss sets that bit and a return-from-exception pulse clears it.

Top module: `mmux_classifier`

## Requirements
- R1: Reset (synchronous, active low) clears the handling bit `eh_q`, the recorded cause `cause_q` and the recorded data flag `data_q` to 0.
- R2: An access of a valid kind that misses while `eh_q` is 0 raises `exc_req` with cause 12 (fast miss) and handler address `FAST_VEC`, in the same cycle.
- R3: An access of a valid kind that misses while `eh_q` is 1 raises `exc_req` with cause 13 (double miss) and handler address `GEN_VEC`. `eh_q` stays 1.
- R4: The data flag is 0 for a fetch (kind 0). It is 1 for a load (1), a store (2), a data-line init (3) and a data-line flush (4). It is recorded into `data_q` with every exception.
- R5: A fetch that hits an entry with `perm_x` = 0 raises cause 14 (execute violation) with handler address `GEN_VEC`.
- R6: A load that hits with `perm_r` = 0 raises cause 15 (read violation). A store that hits with `perm_w` = 0 raises cause 16 (write violation). Both use `GEN_VEC`.
- R7: No exception is raised, and cause is 0, in these cases: `acc_valid` is 0, the kind is 5 to 7, the access is a data-line init or flush that hits, or the access hits with the permission it needs. In all of them `eh_q`, `cause_q` and `data_q` keep their values.
- R8: After a fast miss, `eh_q` is 1 in the next cycle. An `eret` pulse with no fast miss in the same cycle clears it. If both occur in the same cycle, the fast miss wins.
- R9: On every exception, `cause_q` and `data_q` take that exception's cause and data flag on the next clock edge. Otherwise they hold their values.
- R10: When no exception is requested, `exc_vector` shows `GEN_VEC`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | A translation result is present this cycle |
| acc_kind | input | 3 | 0 fetch, 1 load, 2 store, 3 data-line init, 4 data-line flush |
| tlb_hit | input | 1 | A matching entry was found |
| perm_x | input | 1 | Execute permission of the matching entry |
| perm_r | input | 1 | Read permission of the matching entry |
| perm_w | input | 1 | Write permission of the matching entry |
| eret | input | 1 | Return from exception, clears the handling bit |
| exc_req | output | 1 | Exception raised for this access |
| exc_vector | output | VEC_W | Handler address |
| exc_cause | output | 5 | Cause code, 0 when the access is allowed |
| eh_q | output | 1 | Exception-handling bit |
| cause_q | output | 5 | Cause of the last exception |
| data_q | output | 1 | Data flag of the last exception |

## Verification
The assertions assume that the hit flag and the permission bits are settled whenever `acc_valid` is high. They also assume that `acc_kind` is sampled only in that case; outside it the inputs may hold any value. The bench drives every input on the falling edge and holds it through the next rising edge, so each access is sampled with stable inputs. It clears `acc_valid` again before the next access. Every combination of kind, hit, permission bits and handling state is reached by first bringing `eh_q` to the wanted value with a fast miss or an `eret` pulse.

// File: rtl/mmux_pkg.sv
// Shared encodings for the translation exception classifier.
// Assumes a 3-bit access kind and a 5-bit cause field.
package mmux_pkg;
    localparam int CAUSE_W = 5;

    localparam logic [2:0] ACC_FETCH  = 3'd0;
    localparam logic [2:0] ACC_LOAD   = 3'd1;
    localparam logic [2:0] ACC_STORE  = 3'd2;
    localparam logic [2:0] ACC_DINIT  = 3'd3;
    localparam logic [2:0] ACC_DFLUSH = 3'd4;

    localparam logic [CAUSE_W-1:0] C_NONE        = 5'd0;
    localparam logic [CAUSE_W-1:0] C_FAST_MISS   = 5'd12;
    localparam logic [CAUSE_W-1:0] C_DOUBLE_MISS = 5'd13;
    localparam logic [CAUSE_W-1:0] C_EXEC_VIOL   = 5'd14;
    localparam logic [CAUSE_W-1:0] C_READ_VIOL   = 5'd15;
    localparam logic [CAUSE_W-1:0] C_WRITE_VIOL  = 5'd16;

    typedef struct packed {
        logic               req;
        logic               fast;
        logic               data;
        logic [CAUSE_W-1:0] cause;
    } fault_t;
endpackage

// File: rtl/mmux_fault_decode.sv
// Combinational fault decoder: classifies one translation attempt.
// Assumes hit and permission inputs are valid when acc_valid is high;
// kinds above 4 are not accesses and never fault.
module mmux_fault_decode
    import mmux_pkg::*;
(
    input  logic       acc_valid,
    input  logic [2:0] acc_kind,
    input  logic       tlb_hit,
    input  logic       perm_x,
    input  logic       perm_r,
    input  logic       perm_w,
    input  logic       eh,
    output fault_t     fault
);
    logic kind_ok;
    logic miss;

    assign kind_ok = (acc_kind <= ACC_DFLUSH);
    assign miss    = acc_valid && kind_ok && !tlb_hit;

    // Pick cause: miss kinds first, then permission checks by access kind.
    always_comb begin
        fault       = '0;
        fault.data  = (acc_kind != ACC_FETCH);
        fault.cause = C_NONE;
        if (miss) begin
            fault.cause = eh ? C_DOUBLE_MISS : C_FAST_MISS;
            fault.fast  = !eh;
        end else if (acc_valid && tlb_hit) begin
            case (acc_kind)
                ACC_FETCH: if (!perm_x) fault.cause = C_EXEC_VIOL;
                ACC_LOAD:  if (!perm_r) fault.cause = C_READ_VIOL;
                ACC_STORE: if (!perm_w) fault.cause = C_WRITE_VIOL;
                default:   fault.cause = C_NONE;
            endcase
        end
        fault.req = (fault.cause != C_NONE);
    end

    // R7: a permitted fetch never yields an execute fault
    always_comb begin
        if (acc_valid && tlb_hit && perm_x && acc_kind == ACC_FETCH)
            a_r7_fetch_allowed: assert (fault.cause == C_NONE);
    end
endmodule

// File: rtl/mmux_status_reg.sv
// Handling-bit and cause-record registers.
// Assumes the fault struct is settled before the rising clock edge.
module mmux_status_reg
    import mmux_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  fault_t             fault,
    input  logic               eret,
    output logic               eh_q,
    output logic [CAUSE_W-1:0] cause_q,
    output logic               data_q
);
    // Handling bit: set by a fast miss, cleared by return, else held.
    always_ff @(posedge clk) begin
        if (!rst_n)                eh_q <= 1'b0;
        else if (fault.fast)       eh_q <= 1'b1;
        else if (eret)             eh_q <= 1'b0;
    end

    // Record cause and data flag of every exception.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= C_NONE;
            data_q  <= 1'b0;
        end else if (fault.req) begin
            cause_q <= fault.cause;
            data_q  <= fault.data;
        end
    end

    a_r8_fast_sets_eh: assert property (@(posedge clk) disable iff (!rst_n)
        fault.fast |=> eh_q);
    a_r3_double_keeps_eh: assert property (@(posedge clk) disable iff (!rst_n)
        (fault.req && fault.cause == C_DOUBLE_MISS) |=> eh_q);
    a_r8_eret_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (eret && !fault.fast) |=> !eh_q);
    a_r9_record: assert property (@(posedge clk) disable iff (!rst_n)
        fault.req |=> (cause_q == $past(fault.cause) && data_q == $past(fault.data)));
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !fault.req |=> ($stable(cause_q) && $stable(data_q)));
endmodule

// File: rtl/mmux_classifier.sv
// Top of the translation exception classifier: decodes the fault,
// selects the handler address and keeps the status registers.
// Assumes one translation result per cycle, qualified by acc_valid.
module mmux_classifier
    import mmux_pkg::*;
#(
    parameter int               VEC_W    = 32,
    parameter logic [VEC_W-1:0] FAST_VEC = 32'h0000_0100,
    parameter logic [VEC_W-1:0] GEN_VEC  = 32'h0000_0020
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_valid,
    input  logic [2:0]         acc_kind,
    input  logic               tlb_hit,
    input  logic               perm_x,
    input  logic               perm_r,
    input  logic               perm_w,
    input  logic               eret,
    output logic               exc_req,
    output logic [VEC_W-1:0]   exc_vector,
    output logic [CAUSE_W-1:0] exc_cause,
    output logic               eh_q,
    output logic [CAUSE_W-1:0] cause_q,
    output logic               data_q
);
    fault_t fault;

    mmux_fault_decode u_decode (
        .acc_valid (acc_valid),
        .acc_kind  (acc_kind),
        .tlb_hit   (tlb_hit),
        .perm_x    (perm_x),
        .perm_r    (perm_r),
        .perm_w    (perm_w),
        .eh        (eh_q),
        .fault     (fault)
    );

    mmux_status_reg u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .fault   (fault),
        .eret    (eret),
        .eh_q    (eh_q),
        .cause_q (cause_q),
        .data_q  (data_q)
    );

    // Drive request and cause; the fast vector only for a fast miss.
    always_comb begin
        exc_req    = fault.req;
        exc_cause  = fault.cause;
        exc_vector = fault.fast ? FAST_VEC : GEN_VEC;
    end

    a_r2_fast_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_kind <= ACC_DFLUSH && !tlb_hit && !eh_q)
        |-> (exc_req && exc_vector == FAST_VEC && exc_cause == C_FAST_MISS));
    a_r3_general_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_kind <= ACC_DFLUSH && !tlb_hit && eh_q)
        |-> (exc_req && exc_vector == GEN_VEC && exc_cause == C_DOUBLE_MISS));
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> (!exc_req && exc_cause == C_NONE));
    a_r10_idle_vector: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_req |-> (exc_vector == GEN_VEC));
endmodule

// File: tb/mmux_classifier_tb.sv
module mmux_classifier_tb;
    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] FAST = 32'h0000_0100;
    localparam logic [31:0] GEN  = 32'h0000_0020;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [2:0]  acc_kind = 3'd0;
    logic        tlb_hit = 1'b0, perm_x = 1'b0, perm_r = 1'b0, perm_w = 1'b0;
    logic        eret = 1'b0;
    logic        exc_req;
    logic [31:0] exc_vector;
    logic [4:0]  exc_cause;
    logic        eh_q;
    logic [4:0]  cause_q;
    logic        data_q;

    int checks = 0;
    int errors = 0;
    logic       m_eh = 1'b0;
    logic [4:0] m_cause = 5'd0;
    logic       m_data = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mmux_classifier #(.VEC_W(32), .FAST_VEC(FAST), .GEN_VEC(GEN)) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_kind(acc_kind),
        .tlb_hit(tlb_hit), .perm_x(perm_x), .perm_r(perm_r), .perm_w(perm_w),
        .eret(eret), .exc_req(exc_req), .exc_vector(exc_vector),
        .exc_cause(exc_cause), .eh_q(eh_q), .cause_q(cause_q), .data_q(data_q)
    );

    typedef struct packed {
        logic [2:0] kind;
        logic       hit, x, r, w, eh;
        logic [4:0] cause;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TABLE [NV] = '{
        '{3'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 5'd12},
        '{3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd12},
        '{3'd2, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 5'd13},
        '{3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd13},
        '{3'd4, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd12},
        '{3'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 5'd14},
        '{3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 5'd0},
        '{3'd1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 5'd15},
        '{3'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 5'd0},
        '{3'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 5'd16},
        '{3'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 5'd0},
        '{3'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0},
        '{3'd6, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0}
    };

    // Expected cause taken straight from the requirements.
    function automatic logic [4:0] ref_cause(input logic [2:0] k, input logic h,
                                             input logic x, input logic r,
                                             input logic w, input logic e);
        if (k > 3'd4) return 5'd0;
        if (!h) return e ? 5'd13 : 5'd12;
        if (k == 3'd0 && !x) return 5'd14;
        if (k == 3'd1 && !r) return 5'd15;
        if (k == 3'd2 && !w) return 5'd16;
        return 5'd0;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_regs(input string req);
        chk(eh_q == m_eh, req, "eh_q", eh_q, m_eh);
        chk(cause_q == m_cause, req, "cause_q", cause_q, m_cause);
        chk(data_q == m_data, req, "data_q", data_q, m_data);
    endtask

    // One access: drive at negedge, check combinational outputs, then registers.
    task automatic do_access(input logic v, input logic [2:0] k, input logic h,
                             input logic x, input logic r, input logic w,
                             input logic [4:0] exp_c, input string req);
        logic exp_fast;
        @(negedge clk);
        acc_valid = v; acc_kind = k; tlb_hit = h;
        perm_x = x; perm_r = r; perm_w = w;
        #1;
        exp_fast = (exp_c == 5'd12);
        chk(exc_req == (exp_c != 5'd0), req, "exc_req", exc_req, exp_c != 5'd0);
        chk(exc_cause == exp_c, req, "exc_cause", exc_cause, exp_c);
        chk(exc_vector == (exp_fast ? FAST : GEN), req, "exc_vector (R10)",
            exc_vector, exp_fast ? FAST : GEN);
        @(posedge clk);
        #1;
        if (exp_c != 5'd0) begin
            m_cause = exp_c;
            m_data  = (k != 3'd0);
            if (exp_fast) m_eh = 1'b1;
        end
        check_regs(req);
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic pulse_eret();
        @(negedge clk);
        eret = 1'b1;
        @(posedge clk);
        #1;
        m_eh = 1'b0;
        check_regs("R8");
        @(negedge clk);
        eret = 1'b0;
    endtask

    task automatic set_eh(input logic b);
        if (b && !eh_q) do_access(1'b1, 3'd0, 1'b0, 1'b1, 1'b1, 1'b1, 5'd12, "R8");
        if (!b && eh_q) pulse_eret();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check_regs("R1");
        @(negedge clk);
        rst_n = 1'b1;

        // Table of directed vectors (R2..R7)
        for (int i = 0; i < NV; i++) begin
            set_eh(TABLE[i].eh);
            do_access(1'b1, TABLE[i].kind, TABLE[i].hit, TABLE[i].x, TABLE[i].r,
                      TABLE[i].w, TABLE[i].cause, "R2-table R3 R4 R5 R6 R7 R9");
        end

        // Exhaustive sweep against the reference function
        for (int e = 0; e < 2; e++) begin
            for (int k = 0; k < 8; k++) begin
                for (int h = 0; h < 2; h++) begin
                    for (int p = 0; p < 8; p++) begin
                        set_eh(e[0]);
                        do_access(1'b1, k[2:0], h[0], p[2], p[1], p[0],
                                  ref_cause(k[2:0], h[0], p[2], p[1], p[0], e[0]),
                                  "R4 sweep R9");
                    end
                end
            end
        end

        // R7: invalid access with a miss has no effect
        set_eh(1'b0);
        do_access(1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, "R7 idle");
        // R3: double miss keeps the handling bit and records data flag
        set_eh(1'b1);
        do_access(1'b1, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 5'd13, "R3 double");
        chk(data_q == 1'b1, "R4", "data_q flush", data_q, 1);

        // R8: fast miss wins over eret in the same cycle
        set_eh(1'b0);
        @(negedge clk);
        eret = 1'b1;
        do_access(1'b1, 3'd1, 1'b0, 1'b1, 1'b1, 1'b1, 5'd12, "R8 fast over eret");
        eret = 1'b0;
        chk(eh_q == 1'b1, "R8", "eh_q after tie", eh_q, 1);

        // R1: reset in mid-run clears the registers
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        m_eh = 1'b0; m_cause = 5'd0; m_data = 1'b0;
        check_regs("R1 mid-run");
        @(negedge clk);
        rst_n = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule